// File: doc/BRIEF.md
# Dual-Channel Synthesizer Serial Programming Loader

This block takes a three-wire serial stream (shift clock, data and load strobe) and turns it into the control state of a two-channel frequency synthesizer. All three wires are sampled in the system clock domain. Words of 22 bits arrive most significant bit first into one shared shift register. A rising load strobe sends the word to one of four latch sets. The target is picked by the two bits that arrive last: a reference word or a divider word, for channel 1 or for channel 2.

The block holds the latched fields and drives them to the counters, prescalers and charge pumps that sit outside it. It combines each channel's charge-pump high-impedance request with its power-save bit, and it gates the shared oscillator buffer. It also decodes the four monitor-select bits that the two reference words carry. That decoder drives the single monitor pin, which can show lock detect, a divided reference or comparison clock, fastlock control or counter-reset commands. A load whose divide ratio is below 3 is refused, and a one-cycle error pulse is raised.

Word layout, with bit 0 the last bit shifted: bit 0 is the type (0 reference, 1 divider) and bit 1 is the channel (1 for channel 1, 0 for channel 2). A reference word carries the ratio in bits 16:2, then phase invert (17), high current (18), forced high impedance (19), lock select (20) and frequency select (21). A divider word carries the swallow value in bits 8:2, the main value in bits 19:9, the high prescaler modulus in bit 20 and power save in bit 21.

Top module: `syn_prog_if`

## Requirements
- R1: A bit of `sdata_i` is shifted in only on a rising `sclk_i` while `sle_i` is low. Clock edges with `sle_i` high leave the shift register untouched.
- R2: Latched state changes only in the cycle after a rising `sle_i`. Word bit 0 picks reference (0) or divider (1), and bit 1 picks channel 1 (1) or channel 2 (0).
- R3: A reference load sets that channel's ratio (bits 16:2), phase invert (17), high current (18), forced high impedance (19), lock select (20) and frequency select (21).
- R4: A divider load sets that channel's swallow value (bits 8:2), main value (bits 19:9), prescaler modulus (20) and power save (21).
- R5: A reference ratio or main value below 3 leaves that latch unchanged and raises `load_err_o` for one cycle. A value of exactly 3 is accepted.
- R6: `cp_hiz_o` of a channel is high while that channel's forced-impedance bit or power-save bit is set.
- R7: `osc_buf_en_o` is low only while both channels are in power save.
- R8: With both frequency-select bits low, the lock-select pair {ch1,ch2} chooses the monitor output: 00 drives low, 01 gives channel-2 lock, 10 gives channel-1 lock, and 11 gives the AND of both lock inputs.
- R9: With exactly one frequency-select bit high, the monitor shows that channel's `fr_i` when channel-2 lock select is 0, and its `fp_i` when it is 1.
- R10: With both frequency-select bits high and both lock-select bits low (fastlock), the monitor is driven low while the channel-1 high-current bit is set and released (`mon_oe_o` low) otherwise.
- R11: With both frequency-select bits high and a nonzero lock-select pair, `cnt_rst_o[0]` follows channel-1 lock select and `cnt_rst_o[1]` follows channel-2 lock select, and the monitor drives low.
- R12: After reset both channels are in power save, the ratios and main values are 3, all other fields are 0, and the monitor drives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock, already synchronous to clk |
| sdata_i | input | 1 | Serial data |
| sle_i | input | 1 | Load strobe; high stops shifting, rising edge loads |
| lock_i | input | 2 | Lock-detect inputs, bit 0 channel 1 |
| fr_i | input | 2 | Divided reference clocks, bit 0 channel 1 |
| fp_i | input | 2 | Divided comparison clocks, bit 0 channel 1 |
| ref_ratio_o | output | 30 | Reference ratios, ch1 in 14:0, ch2 in 29:15 |
| pd_invert_o | output | 2 | Phase detector polarity invert per channel |
| cp_boost_o | output | 2 | Charge pump high current per channel |
| cp_hiz_o | output | 2 | Charge pump output released per channel |
| swallow_o | output | 14 | Swallow values, ch1 in 6:0, ch2 in 13:7 |
| main_o | output | 22 | Main divider values, ch1 in 10:0, ch2 in 21:11 |
| modulus_hi_o | output | 2 | Larger prescaler modulus selected per channel |
| pwr_save_o | output | 2 | Channel counters held off per channel |
| osc_buf_en_o | output | 1 | Shared oscillator buffer enable |
| cnt_rst_o | output | 2 | Counter reset command per channel |
| mon_val_o | output | 1 | Monitor pin value when driven |
| mon_oe_o | output | 1 | Monitor pin drive enable |
| load_err_o | output | 1 | One-cycle pulse on a refused load |

## Verification
The assertions assume that `sclk_i`, `sdata_i` and `sle_i` are already synchronous to `clk` and are held steady for at least one clock per level. Otherwise edge detection could miss or double a strobe. The stability check also assumes `sle_i` is low through reset, so its previous value is defined. The bench drives every serial level for two clocks on the falling edge of `clk` and holds the strobe low until after reset, which keeps the stimulus inside these assumptions.

// File: rtl/syn_prog_pkg.sv
package syn_prog_pkg;
  localparam int unsigned SP_REF_W   = 15;
  localparam int unsigned SP_SWL_W   = 7;
  localparam int unsigned SP_MAIN_W  = 11;
  localparam int unsigned SP_MIN_DIV = 3;

  typedef enum logic [2:0] {
    MON_OFF,
    MON_LOCK,
    MON_CLK,
    MON_FAST,
    MON_RESET
  } mon_mode_e;
endpackage

// File: rtl/syn_shift_in.sv
module syn_shift_in #(
  parameter int unsigned WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sle_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic sclk_q;
  logic le_q;
  logic shift_en;

  assign shift_en = sclk_i & ~sclk_q & ~sle_i;
  assign load_o   = sle_i & ~le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= sle_i;
      if (shift_en) word_o <= {word_o[WORD_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/syn_chan_latch.sv
module syn_chan_latch #(
  parameter int unsigned REF_W   = 15,
  parameter int unsigned SWL_W   = 7,
  parameter int unsigned MAIN_W  = 11,
  parameter int unsigned MIN_DIV = 3,
  parameter int unsigned WORD_W  = 2 + REF_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_ld_i,
  input  logic              div_ld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [REF_W-1:0]  ratio_o,
  output logic              invert_o,
  output logic              boost_o,
  output logic              hiz_o,
  output logic              lds_o,
  output logic              fds_o,
  output logic [SWL_W-1:0]  swallow_o,
  output logic [MAIN_W-1:0] main_o,
  output logic              mod_hi_o,
  output logic              ps_o,
  output logic              err_o
);
  localparam int unsigned RATIO_LO = 2;
  localparam int unsigned INV_BIT  = RATIO_LO + REF_W;
  localparam int unsigned BST_BIT  = INV_BIT + 1;
  localparam int unsigned ZC_BIT   = INV_BIT + 2;
  localparam int unsigned LDS_BIT  = INV_BIT + 3;
  localparam int unsigned FDS_BIT  = INV_BIT + 4;
  localparam int unsigned SWL_LO   = 2;
  localparam int unsigned MAIN_LO  = SWL_LO + SWL_W;
  localparam int unsigned MOD_BIT  = MAIN_LO + MAIN_W;
  localparam int unsigned PS_BIT   = MOD_BIT + 1;

  logic [REF_W-1:0]  new_ratio;
  logic [MAIN_W-1:0] new_main;
  logic              ratio_bad;
  logic              main_bad;
  logic              zc_q;

  assign new_ratio = word_i[RATIO_LO +: REF_W];
  assign new_main  = word_i[MAIN_LO +: MAIN_W];
  assign ratio_bad = (new_ratio < REF_W'(MIN_DIV));
  assign main_bad  = (new_main < MAIN_W'(MIN_DIV));
  assign hiz_o     = zc_q | ps_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_o   <= REF_W'(MIN_DIV);
      invert_o  <= 1'b0;
      boost_o   <= 1'b0;
      zc_q      <= 1'b0;
      lds_o     <= 1'b0;
      fds_o     <= 1'b0;
      swallow_o <= '0;
      main_o    <= MAIN_W'(MIN_DIV);
      mod_hi_o  <= 1'b0;
      ps_o      <= 1'b1;
      err_o     <= 1'b0;
    end else begin
      err_o <= (ref_ld_i & ratio_bad) | (div_ld_i & main_bad);
      if (ref_ld_i && !ratio_bad) begin
        ratio_o  <= new_ratio;
        invert_o <= word_i[INV_BIT];
        boost_o  <= word_i[BST_BIT];
        zc_q     <= word_i[ZC_BIT];
        lds_o    <= word_i[LDS_BIT];
        fds_o    <= word_i[FDS_BIT];
      end
      if (div_ld_i && !main_bad) begin
        swallow_o <= word_i[SWL_LO +: SWL_W];
        main_o    <= new_main;
        mod_hi_o  <= word_i[MOD_BIT];
        ps_o      <= word_i[PS_BIT];
      end
    end
  end
endmodule

// File: rtl/syn_mon_select.sv
module syn_mon_select
  import syn_prog_pkg::*;
(
  input  logic [1:0] lds_i,
  input  logic [1:0] fds_i,
  input  logic [1:0] lock_i,
  input  logic [1:0] fr_i,
  input  logic [1:0] fp_i,
  input  logic       boost_ch1_i,
  output logic       mon_val_o,
  output logic       mon_oe_o,
  output logic [1:0] cnt_rst_o
);
  mon_mode_e mode;
  logic      clk_ch;

  always_comb begin
    unique case (fds_i)
      2'b00:   mode = (lds_i == 2'b00) ? MON_OFF : MON_LOCK;
      2'b11:   mode = (lds_i == 2'b00) ? MON_FAST : MON_RESET;
      default: mode = MON_CLK;
    endcase
  end

  assign clk_ch = fds_i[0] ? 1'b0 : 1'b1;

  always_comb begin
    mon_val_o = 1'b0;
    mon_oe_o  = 1'b1;
    cnt_rst_o = 2'b00;
    unique case (mode)
      MON_LOCK: begin
        unique case (lds_i)
          2'b10:   mon_val_o = lock_i[1];
          2'b01:   mon_val_o = lock_i[0];
          default: mon_val_o = &lock_i;
        endcase
      end
      MON_CLK:   mon_val_o = lds_i[1] ? fp_i[clk_ch] : fr_i[clk_ch];
      MON_FAST:  mon_oe_o  = boost_ch1_i;
      MON_RESET: cnt_rst_o = lds_i;
      default:   mon_val_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/syn_prog_if.sv
module syn_prog_if
  import syn_prog_pkg::*;
#(
  parameter int unsigned REF_W   = SP_REF_W,
  parameter int unsigned SWL_W   = SP_SWL_W,
  parameter int unsigned MAIN_W  = SP_MAIN_W,
  parameter int unsigned MIN_DIV = SP_MIN_DIV,
  parameter int unsigned NCH     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  input  logic                  sle_i,
  input  logic [NCH-1:0]        lock_i,
  input  logic [NCH-1:0]        fr_i,
  input  logic [NCH-1:0]        fp_i,
  output logic [NCH*REF_W-1:0]  ref_ratio_o,
  output logic [NCH-1:0]        pd_invert_o,
  output logic [NCH-1:0]        cp_boost_o,
  output logic [NCH-1:0]        cp_hiz_o,
  output logic [NCH*SWL_W-1:0]  swallow_o,
  output logic [NCH*MAIN_W-1:0] main_o,
  output logic [NCH-1:0]        modulus_hi_o,
  output logic [NCH-1:0]        pwr_save_o,
  output logic                  osc_buf_en_o,
  output logic [NCH-1:0]        cnt_rst_o,
  output logic                  mon_val_o,
  output logic                  mon_oe_o,
  output logic                  load_err_o
);
  localparam int unsigned WORD_W = 2 + REF_W + 5;

  logic [WORD_W-1:0] word;
  logic              load;
  logic [NCH-1:0]    ref_ld;
  logic [NCH-1:0]    div_ld;
  logic [NCH-1:0]    lds;
  logic [NCH-1:0]    fds;
  logic [NCH-1:0]    err;

  syn_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .sle_i   (sle_i),
    .word_o  (word),
    .load_o  (load)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam logic CH_CODE = (ch == 0) ? 1'b1 : 1'b0;
    assign ref_ld[ch] = load & ~word[0] & (word[1] == CH_CODE);
    assign div_ld[ch] = load &  word[0] & (word[1] == CH_CODE);

    syn_chan_latch #(
      .REF_W   (REF_W),
      .SWL_W   (SWL_W),
      .MAIN_W  (MAIN_W),
      .MIN_DIV (MIN_DIV),
      .WORD_W  (WORD_W)
    ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_ld_i  (ref_ld[ch]),
      .div_ld_i  (div_ld[ch]),
      .word_i    (word),
      .ratio_o   (ref_ratio_o[ch*REF_W +: REF_W]),
      .invert_o  (pd_invert_o[ch]),
      .boost_o   (cp_boost_o[ch]),
      .hiz_o     (cp_hiz_o[ch]),
      .lds_o     (lds[ch]),
      .fds_o     (fds[ch]),
      .swallow_o (swallow_o[ch*SWL_W +: SWL_W]),
      .main_o    (main_o[ch*MAIN_W +: MAIN_W]),
      .mod_hi_o  (modulus_hi_o[ch]),
      .ps_o      (pwr_save_o[ch]),
      .err_o     (err[ch])
    );
  end

  assign osc_buf_en_o = ~&pwr_save_o;
  assign load_err_o   = |err;

  syn_mon_select u_mon (
    .lds_i       (lds[1:0]),
    .fds_i       (fds[1:0]),
    .lock_i      (lock_i[1:0]),
    .fr_i        (fr_i[1:0]),
    .fp_i        (fp_i[1:0]),
    .boost_ch1_i (cp_boost_o[0]),
    .mon_val_o   (mon_val_o),
    .mon_oe_o    (mon_oe_o),
    .cnt_rst_o   (cnt_rst_o[1:0])
  );
endmodule

// File: rtl/syn_prog_if_chk.sv
module syn_prog_if_chk #(
  parameter int unsigned REF_W  = 15,
  parameter int unsigned MAIN_W = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sle_i,
  input logic [2*REF_W-1:0]    ref_ratio_o,
  input logic [2*MAIN_W-1:0]   main_o,
  input logic [1:0]            pwr_save_o,
  input logic [1:0]            cp_boost_o,
  input logic [1:0]            cp_hiz_o,
  input logic                  osc_buf_en_o,
  input logic [1:0]            cnt_rst_o,
  input logic                  mon_val_o,
  input logic                  mon_oe_o,
  input logic                  load_err_o
);
  // latched state moves only after a load strobe edge
  assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sle_i || $past(sle_i)) |=> ($stable(ref_ratio_o) && $stable(main_o) && $stable(pwr_save_o)));

  assert_refused_load_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_err_o |-> ($stable(ref_ratio_o) && $stable(main_o)));

  assert_ps_forces_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save_o & ~cp_hiz_o) == 2'b00);

  assert_osc_off_needs_both_ps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_buf_en_o |-> (pwr_save_o == 2'b11));

  assert_release_only_fastlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_oe_o |-> (!cp_boost_o[0] && cnt_rst_o == 2'b00));

  assert_reset_drives_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst_o != 2'b00) |-> (mon_oe_o && !mon_val_o));
endmodule

bind syn_prog_if syn_prog_if_chk #(.REF_W(REF_W), .MAIN_W(MAIN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sle_i        (sle_i),
  .ref_ratio_o  (ref_ratio_o),
  .main_o       (main_o),
  .pwr_save_o   (pwr_save_o),
  .cp_boost_o   (cp_boost_o),
  .cp_hiz_o     (cp_hiz_o),
  .osc_buf_en_o (osc_buf_en_o),
  .cnt_rst_o    (cnt_rst_o),
  .mon_val_o    (mon_val_o),
  .mon_oe_o     (mon_oe_o),
  .load_err_o   (load_err_o)
);

// File: tb/syn_prog_if_bench.sv
module syn_prog_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [1:0] lock = 2'b00, fr = 2'b00, fp = 2'b00;
  logic [29:0] ref_ratio;
  logic [1:0]  pd_inv, boost, hiz, mod_hi, ps, cnt_rst;
  logic [13:0] swallow;
  logic [21:0] main_v;
  logic osc_en, mon_val, mon_oe, load_err;
  int checks = 0, errors = 0, err_pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  syn_prog_if u_syn_prog_if (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .lock_i(lock), .fr_i(fr), .fp_i(fp),
    .ref_ratio_o(ref_ratio), .pd_invert_o(pd_inv), .cp_boost_o(boost),
    .cp_hiz_o(hiz), .swallow_o(swallow), .main_o(main_v),
    .modulus_hi_o(mod_hi), .pwr_save_o(ps), .osc_buf_en_o(osc_en),
    .cnt_rst_o(cnt_rst), .mon_val_o(mon_val), .mon_oe_o(mon_oe),
    .load_err_o(load_err)
  );

  always @(negedge clk) if (rst_n && load_err) err_pulses++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [21:0] w);
    for (int i = 21; i >= 0; i--) begin
      sdata = w[i]; tick(2);
      sclk = 1'b1;  tick(2);
      sclk = 1'b0;
    end
    tick(2); sle = 1'b1; tick(2); sle = 1'b0; tick(2);
  endtask

  function automatic logic [21:0] ref_word(input logic ch1, input logic [14:0] r,
      input logic inv, input logic bst, input logic zc, input logic lds, input logic fds);
    return {fds, lds, zc, bst, inv, r, ch1, 1'b0};
  endfunction

  function automatic logic [21:0] div_word(input logic ch1, input logic [6:0] a,
      input logic [10:0] n, input logic sw, input logic p);
    return {p, sw, n, a, ch1, 1'b1};
  endfunction

  task automatic t_reset;
    chk("R12 ratios", ref_ratio, {15'd3, 15'd3});
    chk("R12 mains", main_v, {11'd3, 11'd3});
    chk("R12 ps", ps, 2'b11);
    chk("R7 osc off at reset", osc_en, 1'b0);
    chk("R6 hiz at reset", hiz, 2'b11);
    chk("R12 monitor", {mon_oe, mon_val, cnt_rst}, 4'b1000);
  endtask

  task automatic t_ref_route;
    send_word(ref_word(1'b1, 15'd1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R3 ch1 ratio", ref_ratio[14:0], 15'd1234);
    chk("R3 ch1 invert", pd_inv, 2'b01);
    chk("R2 ch2 untouched", ref_ratio[29:15], 15'd3);
    send_word(ref_word(1'b0, 15'd32767, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    chk("R3 ch2 ratio", ref_ratio[29:15], 15'd32767);
    chk("R3 ch2 boost", boost, 2'b10);
    chk("R2 ch1 kept", ref_ratio[14:0], 15'd1234);
  endtask

  task automatic t_div_ps;
    send_word(div_word(1'b1, 7'd127, 11'd2047, 1'b1, 1'b0));
    chk("R4 ch1 swallow", swallow[6:0], 7'd127);
    chk("R4 ch1 main", main_v[10:0], 11'd2047);
    chk("R4 ch1 modulus", mod_hi, 2'b01);
    chk("R4 ch1 ps", ps, 2'b10);
    chk("R7 osc on one awake", osc_en, 1'b1);
    chk("R6 hiz zc/ps", hiz, 2'b10);
    send_word(div_word(1'b0, 7'd5, 11'd3, 1'b0, 1'b0));
    chk("R4 ch2 swallow", swallow[13:7], 7'd5);
    chk("R2 ch1 swallow kept", swallow[6:0], 7'd127);
    chk("R6 ch2 zc keeps hiz", hiz, 2'b10);
    send_word(ref_word(1'b0, 15'd32767, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R6 hiz released", hiz, 2'b00);
  endtask

  task automatic t_errors;
    int base = err_pulses;
    send_word(ref_word(1'b1, 15'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R5 ch1 ratio kept", ref_ratio[14:0], 15'd1234);
    chk("R5 error pulse", err_pulses - base, 1);
    send_word(div_word(1'b0, 7'd9, 11'd1, 1'b1, 1'b1));
    chk("R5 ch2 main kept", main_v[21:11], 11'd3);
    chk("R5 ch2 ps kept", ps, 2'b00);
    chk("R5 second pulse", err_pulses - base, 2);
    send_word(ref_word(1'b0, 15'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    chk("R5 ratio 3 accepted", ref_ratio[29:15], 15'd3);
    chk("R5 no pulse at 3", err_pulses - base, 2);
  endtask

  task automatic t_le_high_ignored;
    sle = 1'b1; sdata = 1'b1;
    repeat (5) begin tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; end
    tick(2); sle = 1'b0; tick(2); sle = 1'b1; tick(2); sle = 1'b0; tick(2);
    sdata = 1'b0;
    chk("R1 ch1 main unchanged", main_v[10:0], 11'd2047);
    chk("R1 ch2 ratio reloaded same", ref_ratio[29:15], 15'd3);
    chk("R1 ch1 ratio unchanged", ref_ratio[14:0], 15'd1234);
  endtask

  task automatic set_sel(input logic l1, input logic f1, input logic l2,
                         input logic f2, input logic b1);
    send_word(ref_word(1'b1, 15'd100, 1'b0, b1, 1'b0, l1, f1));
    send_word(ref_word(1'b0, 15'd200, 1'b0, 1'b0, 1'b0, l2, f2));
  endtask

  task automatic t_monitor;
    set_sel(0, 0, 0, 0, 0);
    lock = 2'b11; tick(1);
    chk("R8 disabled low", {mon_oe, mon_val}, 2'b10);
    set_sel(0, 0, 1, 0, 0);
    lock = 2'b10; tick(1); chk("R8 ch2 lock high", mon_val, 1'b1);
    lock = 2'b01; tick(1); chk("R8 ch2 lock low", mon_val, 1'b0);
    set_sel(1, 0, 0, 0, 0);
    tick(1); chk("R8 ch1 lock", mon_val, 1'b1);
    set_sel(1, 0, 1, 0, 0);
    tick(1); chk("R8 AND one locked", mon_val, 1'b0);
    lock = 2'b11; tick(1); chk("R8 AND both locked", mon_val, 1'b1);
    lock = 2'b00;
    set_sel(0, 0, 0, 1, 0);
    fr = 2'b10; fp = 2'b00; tick(1); chk("R9 ch2 fr", mon_val, 1'b1);
    set_sel(0, 0, 1, 1, 0);
    tick(1); chk("R9 ch2 fp low", mon_val, 1'b0);
    fp = 2'b10; fr = 2'b00; tick(1); chk("R9 ch2 fp high", mon_val, 1'b1);
    set_sel(0, 1, 1, 0, 0);
    fp = 2'b01; tick(1); chk("R9 ch1 fp", mon_val, 1'b1);
    set_sel(0, 1, 0, 0, 0);
    fr = 2'b01; fp = 2'b00; tick(1); chk("R9 ch1 fr", mon_val, 1'b1);
    fr = 2'b00;
    set_sel(0, 1, 0, 1, 1);
    tick(1); chk("R10 fastlock drive low", {mon_oe, mon_val, cnt_rst}, 4'b1000);
    set_sel(0, 1, 0, 1, 0);
    tick(1); chk("R10 fastlock released", {mon_oe, cnt_rst}, 3'b000);
    set_sel(0, 1, 1, 1, 0);
    tick(1); chk("R11 reset ch2", {mon_oe, mon_val, cnt_rst}, 4'b1010);
    set_sel(1, 1, 0, 1, 0);
    tick(1); chk("R11 reset ch1", cnt_rst, 2'b01);
    set_sel(1, 1, 1, 1, 0);
    tick(1); chk("R11 reset both", cnt_rst, 2'b11);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_ref_route();
    t_div_ps();
    t_errors();
    t_le_high_ignored();
    t_monitor();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule